// File: doc/BRIEF.md
# SPI Serial-EEPROM Read Responder

This block is an SPI slave that answers a boot master as if it were a serial EEPROM holding the boot image. The master lowers chip select and clocks in a read opcode and a 16-bit start address, most significant bit first. The block then streams bytes from an attached image memory on MISO, starting at that address and stepping by one byte for as long as chip select stays low.

All SPI pins are sampled through synchronizers into a faster system clock. The image memory sits behind a simple byte-wide read port with a single-cycle read strobe. Only the read sequence is answered. A master that aborts early, for example after a few header bytes, can lower chip select again right away, and decoding starts over.

Top module: `spi_rom_resp`

## Requirements
- R1: After reset and whenever chip select is high, MISO is 1 and `mem_rd` is 0. MISO also stays 1 during the 24 command and address bit times of a transfer.
- R2: The interface runs in SPI mode 0. MOSI is sampled on the rising SCLK edge, most significant bit first, and the first 8 bits after chip select falls form the command byte. The value 0x03 selects a read.
- R3: After a 0x03 command, the next 16 bits, most significant bit first, form the start address. The first memory read issued in the transfer uses exactly that address.
- R4: Bit 7 of the byte at the start address appears on MISO at the falling SCLK edge that follows the 24th rising edge. Every later data bit also changes only on a falling edge, most significant bit first, so the master reads it on the next rising edge.
- R5: Each further byte comes from the previous address plus one, and the address wraps from 0xFFFF to 0x0000.
- R6: For any command byte other than 0x03, MISO stays 1 and no memory read is issued until chip select goes high.
- R7: Each assertion of chip select restarts command decoding. This holds even when the previous transfer was cut off mid-address or after any number of data bytes, and when the next assertion follows after only a short high time.
- R8: `mem_rd` is a pulse exactly one system clock long, with `mem_addr` valid in that cycle. `mem_data` is taken on the system clock cycle after the pulse.
- R9: Operation is correct whenever the system clock is at least 8 times the SCLK frequency. SCLK, MOSI and chip select each pass through `SYNC_STAGES` (at least 2) flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sclk | input | 1 | Serial clock from the master, idle low |
| spi_cs_n | input | 1 | Active-low chip select from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, 1 when idle |
| mem_rd | output | 1 | One-cycle read strobe to the image memory |
| mem_addr | output | ADDR_W | Image memory byte address |
| mem_data | input | DATA_W | Image memory read data, valid the cycle after `mem_rd` |

## Verification
The bench targets the first data bit at the fastest allowed SCLK, where the fetch of the first byte only just lands before the falling edge. A late prefetch there would shift the whole stream by a bit or send stale bytes. It also reads across the 0xFFFF boundary, where a missing wrap or an extra increment sends wrong bytes. It sends unknown opcodes, where a responder that decoded loosely would start driving data or strobing the memory. Finally it cuts transfers off mid-address and after four data bytes, then reselects at once. A responder that kept its bit counters across chip select would misread the next command.

// File: rtl/spirr_pkg.sv
package spirr_pkg;

   // decoder phases of one chip-select window
   typedef enum logic [1:0] {
      ST_CMD  = 2'd0,
      ST_ADDR = 2'd1,
      ST_DATA = 2'd2,
      ST_SKIP = 2'd3
   } rd_state_e;

   localparam int unsigned CMD_BITS = 8;

endpackage

// File: rtl/spirr_sync.sv
module spirr_sync #(
   parameter int unsigned W            = 1,
   parameter int unsigned STAGES       = 2,
   parameter logic [W-1:0] RST_VAL     = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/spirr_edge.sv
module spirr_edge #(
   parameter logic IDLE_LVL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic rise,
   output logic fall
);

   logic lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_q <= IDLE_LVL;
      else        lvl_q <= lvl;
   end

   assign rise = lvl & ~lvl_q;
   assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/spirr_rx.sv
module spirr_rx
   import spirr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 16,
   parameter logic [CMD_BITS-1:0] READ_CMD = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              rise,
   input  logic              mosi_s,
   output rd_state_e         st,
   output logic              start_vld,
   output logic [ADDR_W-1:0] start_addr
);

   localparam int unsigned CNT_W = $clog2(ADDR_W);

   rd_state_e         st_q;
   logic [ADDR_W-1:0] shreg;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] shreg_nx;

   assign shreg_nx = {shreg[ADDR_W-2:0], mosi_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_CMD;
         shreg      <= '0;
         cnt        <= '0;
         start_vld  <= 1'b0;
         start_addr <= '0;
      end else begin
         start_vld <= 1'b0;
         if (!cs_act) begin
            st_q <= ST_CMD;
            cnt  <= '0;
         end else if (rise) begin
            unique case (st_q)
               ST_CMD: begin
                  shreg <= shreg_nx;
                  if (cnt == CNT_W'(CMD_BITS - 1)) begin
                     cnt  <= '0;
                     st_q <= (shreg_nx[CMD_BITS-1:0] == READ_CMD) ? ST_ADDR : ST_SKIP;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               ST_ADDR: begin
                  shreg <= shreg_nx;
                  if (cnt == CNT_W'(ADDR_W - 1)) begin
                     cnt        <= '0;
                     st_q       <= ST_DATA;
                     start_vld  <= 1'b1;
                     start_addr <= shreg_nx;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign st = st_q;

   AST_RESTART_ON_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (st_q == ST_CMD));                                   // R7
   AST_SKIP_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_SKIP) |-> !start_vld);                               // R6

endmodule

// File: rtl/spirr_tx.sv
module spirr_tx #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_act,
   input  logic              fall,
   input  logic              in_data,
   input  logic              start_vld,
   input  logic [ADDR_W-1:0] start_addr,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data,
   output logic              miso
);

   localparam int unsigned BC_W = $clog2(DATA_W);

   logic [ADDR_W-1:0] ptr;
   logic              rd_q;
   logic              cap_q;
   logic [DATA_W-1:0] nxt;
   logic [DATA_W-1:0] sh;
   logic [BC_W-1:0]   bcnt;
   logic              miso_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr    <= '0;
         rd_q   <= 1'b0;
         cap_q  <= 1'b0;
         nxt    <= '1;
         sh     <= '1;
         bcnt   <= '0;
         miso_q <= 1'b1;
      end else if (!cs_act) begin
         rd_q   <= 1'b0;
         cap_q  <= 1'b0;
         bcnt   <= '0;
         miso_q <= 1'b1;
      end else begin
         rd_q  <= 1'b0;
         cap_q <= rd_q;
         if (cap_q) nxt <= mem_data;
         if (rd_q)  ptr <= ptr + 1'b1;
         if (start_vld) begin
            ptr  <= start_addr;
            rd_q <= 1'b1;
            bcnt <= '0;
         end else if (fall && in_data) begin
            if (bcnt == '0) begin
               miso_q <= nxt[DATA_W-1];
               sh     <= {nxt[DATA_W-2:0], 1'b0};
               rd_q   <= 1'b1;
            end else begin
               miso_q <= sh[DATA_W-1];
               sh     <= {sh[DATA_W-2:0], 1'b0};
            end
            if (bcnt == BC_W'(DATA_W - 1)) bcnt <= '0;
            else                           bcnt <= bcnt + 1'b1;
         end
      end
   end

   assign mem_rd   = rd_q;
   assign mem_addr = ptr;
   assign miso     = miso_q;

   // checker state: last address strobed within this transfer
   logic [ADDR_W-1:0] chk_last;
   logic              chk_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chk_last <= '0;
         chk_seen <= 1'b0;
      end else if (!cs_act || start_vld) begin
         chk_seen <= 1'b0;
      end else if (mem_rd) begin
         chk_last <= mem_addr;
         chk_seen <= 1'b1;
      end
   end

   AST_IDLE_MISO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> miso);                                               // R1
   AST_NO_READ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> !mem_rd);                                            // R1
   AST_FIRST_READ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      start_vld |=> (mem_rd && mem_addr == $past(start_addr)));        // R3
   AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_act && $past(cs_act) && !$past(fall)) |-> $stable(miso));    // R4
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && chk_seen) |-> (mem_addr == chk_last + 1'b1));         // R5
   AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |=> !mem_rd);                                             // R8

endmodule

// File: rtl/spi_rom_resp.sv
module spi_rom_resp
   import spirr_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [CMD_BITS-1:0] READ_CMD = 8'h03
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sclk,
   input  logic              spi_cs_n,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              mem_rd,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_data
);

   // elaboration-time parameter checks
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < CMD_BITS || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between the command width and 32");
   end
   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data
      $error("DATA_W must lie between 2 and 32");
   end

   // pin synchronizers: {cs_n, sclk, mosi}
   logic [2:0] pins_s;
   spirr_sync #(
      .W       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b100)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_cs_n, spi_sclk, spi_mosi}),
      .q     (pins_s)
   );

   logic cs_act, sclk_s, mosi_s;
   assign cs_act = ~pins_s[2];
   assign sclk_s = pins_s[1];
   assign mosi_s = pins_s[0];

   logic sclk_rise, sclk_fall;
   spirr_edge #(.IDLE_LVL(1'b0)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (sclk_s),
      .rise  (sclk_rise),
      .fall  (sclk_fall)
   );

   rd_state_e         st;
   logic              start_vld;
   logic [ADDR_W-1:0] start_addr;

   spirr_rx #(
      .ADDR_W   (ADDR_W),
      .READ_CMD (READ_CMD)
   ) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .rise       (sclk_rise),
      .mosi_s     (mosi_s),
      .st         (st),
      .start_vld  (start_vld),
      .start_addr (start_addr)
   );

   spirr_tx #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_act     (cs_act),
      .fall       (sclk_fall),
      .in_data    (st == ST_DATA),
      .start_vld  (start_vld),
      .start_addr (start_addr),
      .mem_rd     (mem_rd),
      .mem_addr   (mem_addr),
      .mem_data   (mem_data),
      .miso       (spi_miso)
   );

   AST_SKIP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_SKIP) |-> (spi_miso && !mem_rd));                      // R6
   AST_HEADER_MISO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CMD || st == ST_ADDR) |-> spi_miso);                   // R1

endmodule

// File: tb/test_spi_rom_resp.sv
module test_spi_rom_resp;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sclk = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_mosi = 1'b0;
   logic        spi_miso;
   logic        mem_rd;
   logic [15:0] mem_addr;
   logic [7:0]  mem_data = 8'h00;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;   // 100 MHz

   spi_rom_resp i_spi_rom_resp (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sclk (spi_sclk),
      .spi_cs_n (spi_cs_n),
      .spi_mosi (spi_mosi),
      .spi_miso (spi_miso),
      .mem_rd   (mem_rd),
      .mem_addr (mem_addr),
      .mem_data (mem_data)
   );

   // image contents as a pure function of address
   function automatic logic [7:0] img(input logic [15:0] a);
      return a[7:0] ^ {a[12:8], a[15:13]} ^ 8'h5C;
   endfunction

   // image memory model: data valid the cycle after the strobe (R8)
   always @(posedge clk) if (mem_rd) mem_data <= img(mem_addr);

   // read monitor
   int          mon_reads = 0;
   int          pulse_err = 0;
   logic        rd_prev = 1'b0;
   logic [15:0] rd_log [64];
   always @(posedge clk) begin
      if (mem_rd) begin
         rd_log[mon_reads % 64] = mem_addr;
         mon_reads = mon_reads + 1;
      end
      if (mem_rd && rd_prev) pulse_err = pulse_err + 1;
      rd_prev = mem_rd;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   logic [7:0]  rx_bytes [16];
   bit          hdr_high;
   int          rd_base;

   // mode-0 master; stop_bits > 0 cuts the transfer off after that many bits
   task automatic spi_xfer(input logic [7:0] cmd, input logic [15:0] addr,
                           input int nbytes, input int stop_bits, input int half);
      logic [23:0] hdr;
      int total;
      hdr = {cmd, addr};
      total = (stop_bits > 0) ? stop_bits : 24 + 8 * nbytes;
      rd_base = mon_reads;
      hdr_high = 1;
      for (int k = 0; k < 16; k++) rx_bytes[k] = 8'h00;
      spi_cs_n = 1'b0;
      repeat (half) @(negedge clk);
      for (int i = 0; i < total; i++) begin
         spi_mosi = (i < 24) ? hdr[23 - i] : 1'b0;
         repeat (half) @(negedge clk);
         if (i < 24) begin
            if (!spi_miso) hdr_high = 0;
         end else begin
            rx_bytes[(i - 24) / 8][7 - ((i - 24) % 8)] = spi_miso;
         end
         spi_sclk = 1'b1;
         repeat (half) @(negedge clk);
         spi_sclk = 1'b0;
      end
      repeat (half) @(negedge clk);
      spi_cs_n = 1'b1;
      repeat (half) @(negedge clk);
   endtask

   task automatic check_read(input logic [15:0] addr, input int nbytes, input string req);
      chk(hdr_high, "R1 header MISO high", 32'(hdr_high), 32'd1);
      chk(mon_reads > rd_base && rd_log[rd_base % 64] == addr, "R3 first read address",
          32'(rd_log[rd_base % 64]), 32'(addr));
      for (int k = 0; k < nbytes; k++) begin
         logic [15:0] a;
         a = addr + 16'(k);
         chk(rx_bytes[k] == img(a), req, 32'(rx_bytes[k]), 32'(img(a)));
      end
   endtask

   task automatic check_ignored(input int nbytes, input string req);
      chk(mon_reads == rd_base, {req, " no memory read"}, 32'(mon_reads - rd_base), 32'd0);
      for (int k = 0; k < nbytes; k++)
         chk(rx_bytes[k] == 8'hFF, {req, " MISO high"}, 32'(rx_bytes[k]), 32'hFF);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (5) @(negedge clk);
      chk(spi_miso === 1'b1, "R1 reset MISO", 32'(spi_miso), 32'd1);
      chk(mem_rd === 1'b0, "R1 reset mem_rd", 32'(mem_rd), 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(spi_miso === 1'b1, "R1 idle MISO", 32'(spi_miso), 32'd1);

      // R2 R3 R4: basic read
      spi_xfer(8'h03, 16'h0100, 4, 0, 8);
      check_read(16'h0100, 4, "R4 data byte");

      // R5: wrap across 0xFFFF
      spi_xfer(8'h03, 16'hFFFE, 4, 0, 8);
      check_read(16'hFFFE, 4, "R5 wrap byte");

      // R6: unknown opcodes
      spi_xfer(8'h0B, 16'h0100, 3, 0, 8);
      check_ignored(3, "R6 cmd 0B");
      spi_xfer(8'h02, 16'h0003, 2, 0, 8);
      check_ignored(2, "R6 cmd 02");
      spi_xfer(8'h83, 16'h1234, 2, 0, 8);   // only low-order bits match
      check_ignored(2, "R6 cmd 83");

      // R7: abort after 4 data bytes, then reselect at once
      spi_xfer(8'h03, 16'h2000, 4, 0, 8);
      check_read(16'h2000, 4, "R7 before abort");
      spi_xfer(8'h03, 16'h0010, 3, 0, 8);
      check_read(16'h0010, 3, "R7 after abort");
      // R7: cut off mid-address, and mid-data-byte
      spi_xfer(8'h03, 16'hABCD, 0, 14, 8);
      spi_xfer(8'h03, 16'h0555, 2, 0, 8);
      check_read(16'h0555, 2, "R7 after partial address");
      spi_xfer(8'h03, 16'h7777, 0, 29, 8);
      spi_xfer(8'h03, 16'h4321, 2, 0, 8);
      check_read(16'h4321, 2, "R7 after partial byte");

      // R9: fastest allowed SCLK (system clock 8x SCLK)
      spi_xfer(8'h03, 16'h0F0F, 3, 0, 4);
      check_read(16'h0F0F, 3, "R9 8x ratio byte");
      spi_xfer(8'h03, 16'hFFFF, 2, 0, 4);
      check_read(16'hFFFF, 2, "R9 R5 fast wrap byte");

      // random mix
      for (int n = 0; n < 16; n++) begin
         logic [7:0]  c;
         logic [15:0] a;
         int          nb;
         int          hf;
         a  = 16'($urandom);
         nb = 1 + int'($urandom % 8);
         hf = ($urandom % 2 == 0) ? 4 : 4 + int'($urandom % 9);
         c  = ($urandom % 5 == 0) ? 8'($urandom) : 8'h03;
         spi_xfer(c, a, nb, 0, hf);
         if (c == 8'h03) check_read(a, nb, "R2 R4 random byte");
         else            check_ignored(nb, "R6 random cmd");
      end

      chk(pulse_err == 0, "R8 single-cycle strobe", 32'(pulse_err), 32'd0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule